// File: doc/BRIEF.md
# Link and Speed Status Indicator Driver

This block drives the two status indicators of a 10/100 Ethernet transceiver. The first indicator reports the link. It is lit steadily while a valid link is present. It blinks while carrier sense shows traffic on the line, and it stays dark whenever the link is down. The second indicator reports the speed. It is lit when the port runs at 100 Mbit/s. It goes dark at 10 Mbit/s, and it also goes dark while the line-isolate control bit is set.

Each indicator pin has its own polarity strap, so a board can wire its lamp active-high or active-low. The blink timing comes from a prescaler whose half period is a parameter. A blink cycle is one dark half followed by one lit half. Once a cycle has begun it always runs to its end. A short burst of activity therefore always gives one visible blink, and the lamp returns to steady lit only when a cycle boundary arrives with no carrier.

Top module: `led_status_top`

## Requirements
- R1: The polarity straps `link_pol` and `speed_pol` select each pin's level: 1 means the pin is high when its lamp is lit, 0 means the pin is low when lit. While reset is held, and on the first cycles after it, both lamps are unlit, so each pin sits at its inactive level.
- R2: With the link up and no blink cycle in progress, the link lamp is lit steadily.
- R3: While `link_ok` is low, the link lamp is unlit whatever `carrier` does. Dropping the link abandons any blink cycle in progress.
- R4: If `carrier` is high at an edge where the link is up and no cycle is running, a blink cycle starts. The lamp is unlit for `HALF_CYCLES` clocks and then lit for `HALF_CYCLES` clocks, a period of 2*`HALF_CYCLES`.
- R5: A cycle that has begun is always completed, even if `carrier` falls partway through it. At the edge that ends a cycle, a high `carrier` starts the next cycle at once. A low `carrier` at that edge leaves the lamp steadily lit.
- R6: The speed lamp is lit when `speed_100` is high and `isolate` is low.
- R7: The speed lamp is unlit while `speed_100` is low (10 Mbit/s).
- R8: The speed lamp is unlit while `isolate` is high, whatever the speed.
- R9: The lamp states are registered. An input change sampled at a clock edge shows at the pins just after that edge, while a change in a polarity strap shows at the pins without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_ok | input | 1 | A valid link is present |
| carrier | input | 1 | Carrier sense (line activity) |
| speed_100 | input | 1 | Resolved speed: 1 = 100 Mbit/s, 0 = 10 Mbit/s |
| isolate | input | 1 | Line-isolate control bit |
| link_pol | input | 1 | Polarity strap for the link pin (1 = active-high) |
| speed_pol | input | 1 | Polarity strap for the speed pin (1 = active-high) |
| link_led | output | 1 | Link/activity indicator pin |
| speed_led | output | 1 | Speed indicator pin |

## Verification
The bench sends carrier bursts of every length from one clock up to several blink periods, with both polarity straps. A design that cut a cycle short when carrier fell would fail on the short bursts. A design that re-sampled carrier partway through a cycle would lose its 50% duty or its period. A design that missed the restart edge would leave a gap between cycles. Link loss in the middle of a blink is checked, together with recovery with carrier both high and low. A design that kept blinking with no link, or that resumed a stale phase, shows up as a wrong pin level. All combinations of speed, isolate and polarity are swept for the speed lamp, which exposes a design that ignores isolate or inverts the strap.

// File: rtl/led_status_pkg.sv
package led_status_pkg;

    // Phase of a blink cycle: a cycle opens dark, then closes lit.
    typedef enum logic {
        PH_LIT  = 1'b0,
        PH_DARK = 1'b1
    } blink_phase_e;

    // Registered lamp states, before the polarity stage.
    typedef struct packed {
        logic link_lit;
        logic speed_lit;
    } lamp_state_t;

    localparam int unsigned NUM_LAMPS = 2;

endpackage

// File: rtl/led_blink_timer.sv
module led_blink_timer
    import led_status_pkg::*;
#(
    parameter int unsigned HALF_CYCLES = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_ok,
    input  logic carrier,
    output logic lit
);

    localparam int unsigned CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_CYCLES - 1);

    typedef struct packed {
        logic          busy;
        blink_phase_e  phase;
        logic [CW-1:0] cnt;
        logic          lit;
    } blink_state_t;

    blink_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!link_ok) begin
            st_d.busy  = 1'b0;
            st_d.phase = PH_LIT;
            st_d.cnt   = '0;
        end else if (!st_q.busy) begin
            if (carrier) begin
                st_d.busy  = 1'b1;
                st_d.phase = PH_DARK;
                st_d.cnt   = '0;
            end
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.cnt = '0;
            if (st_q.phase == PH_DARK) begin
                st_d.phase = PH_LIT;
            end else if (carrier) begin
                st_d.phase = PH_DARK;
            end else begin
                st_d.busy = 1'b0;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.lit = link_ok && !(st_d.busy && st_d.phase == PH_DARK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lit = st_q.lit;

    AST_LINK_DOWN_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !link_ok |=> !lit) else $error("link lamp lit without link"); // R3

    AST_BLINK_OPENS_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (link_ok && !st_q.busy && carrier) |=> !lit) else $error("cycle did not open dark"); // R4

    AST_IDLE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (link_ok && !st_q.busy && !carrier) |=> lit) else $error("idle lamp not lit"); // R2

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_LAST) else $error("prescaler overrun"); // R4

    AST_PHASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (link_ok && st_q.busy && st_q.cnt != CNT_LAST) |=> $stable(st_q.phase)) else $error("phase moved mid-half"); // R5

endmodule

// File: rtl/led_polarity.sv
module led_polarity #(
    parameter int unsigned N = 2
) (
    input  logic [N-1:0] lit,
    input  logic [N-1:0] pol,
    output logic [N-1:0] pin
);

    for (genvar i = 0; i < N; i++) begin : g_lamp
        // pol = 1: pin high when lit; pol = 0: pin low when lit
        assign pin[i] = pol[i] ? lit[i] : !lit[i];
    end

endmodule

// File: rtl/led_status_top.sv
module led_status_top
    import led_status_pkg::*;
#(
    parameter int unsigned HALF_CYCLES = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_ok,
    input  logic carrier,
    input  logic speed_100,
    input  logic isolate,
    input  logic link_pol,
    input  logic speed_pol,
    output logic link_led,
    output logic speed_led
);

    lamp_state_t lamp;
    logic        speed_lit_d, speed_lit_q;
    logic        link_lit;
    logic [NUM_LAMPS-1:0] pins;

    led_blink_timer #(
        .HALF_CYCLES(HALF_CYCLES)
    ) u_blink (
        .clk    (clk),
        .rst_n  (rst_n),
        .link_ok(link_ok),
        .carrier(carrier),
        .lit    (link_lit)
    );

    always_comb begin
        speed_lit_d = speed_100 && !isolate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            speed_lit_q <= 1'b0;
        end else begin
            speed_lit_q <= speed_lit_d;
        end
    end

    assign lamp.link_lit  = link_lit;
    assign lamp.speed_lit = speed_lit_q;

    led_polarity #(
        .N(NUM_LAMPS)
    ) u_pol (
        .lit({lamp.speed_lit, lamp.link_lit}),
        .pol({speed_pol, link_pol}),
        .pin(pins)
    );

    assign link_led  = pins[0];
    assign speed_led = pins[1];

    AST_ISOLATE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        isolate |=> (speed_led == !speed_pol)) else $error("speed lamp lit in isolate"); // R8

    AST_SLOW_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !speed_100 |=> !lamp.speed_lit) else $error("speed lamp lit at 10M"); // R7

    AST_FAST_LIT: assert property (@(posedge clk) disable iff (!rst_n)
        (speed_100 && !isolate) |=> lamp.speed_lit) else $error("speed lamp dark at 100M"); // R6

endmodule

// File: tb/led_status_top_test.sv
module led_status_top_test;

    localparam int H = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_ok = 1'b0, carrier = 1'b0, speed_100 = 1'b0, isolate = 1'b0;
    logic link_pol = 1'b1, speed_pol = 1'b1;
    logic link_led, speed_led;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    led_status_top #(.HALF_CYCLES(H)) uut (
        .clk(clk), .rst_n(rst_n), .link_ok(link_ok), .carrier(carrier),
        .speed_100(speed_100), .isolate(isolate), .link_pol(link_pol),
        .speed_pol(speed_pol), .link_led(link_led), .speed_led(speed_led)
    );

    function automatic logic pin_of(logic lit_v, logic pol_v);
        return pol_v ? lit_v : !lit_v;
    endfunction

    task automatic check(input logic got, input logic exp, input string req);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%b expected=%b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic settle_idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset levels for each strap value
        #1;
        check(link_led, 1'b0, "R1 reset link pin pol=1");
        check(speed_led, 1'b0, "R1 reset speed pin pol=1");
        link_pol = 1'b0; speed_pol = 1'b0; #1;
        check(link_led, 1'b1, "R1 reset link pin pol=0");
        check(speed_led, 1'b1, "R1 reset speed pin pol=0");
        #30 rst_n = 1'b1;
        step();
        check(link_led, 1'b1, "R1 after reset link unlit pol=0");

        // R2 / R9: link up, no carrier -> steady lit one edge later
        @(negedge clk); link_ok = 1'b1; link_pol = 1'b1;
        step();
        check(link_led, 1'b1, "R9 R2 link lit after one edge");
        for (int i = 0; i < 4; i++) begin
            step();
            check(link_led, 1'b1, "R2 steady lit");
        end

        // R4 / R5: bursts of every length, both polarities
        for (int p = 0; p < 2; p++) begin
            for (int len = 1; len <= 4 * 2 * H + 1; len++) begin
                int ncyc;
                int span;
                logic exp_lit;
                link_pol = p[0];
                settle_idle(2 * H + 2);
                ncyc = (len + 2 * H - 1) / (2 * H);
                span = 2 * H * ncyc + 3;
                @(negedge clk); carrier = 1'b1;
                for (int k = 0; k < span; k++) begin
                    step();
                    exp_lit = !((k < 2 * H * ncyc) && ((k % (2 * H)) < H));
                    check(link_led, pin_of(exp_lit, link_pol),
                          (k >= len) ? "R5 cycle completion" : "R4 blink timing");
                    if (k == len - 1) carrier = 1'b0;
                end
            end
        end

        // R3: link drop mid-blink with carrier high
        link_pol = 1'b1;
        @(negedge clk); carrier = 1'b1;
        step(); step();
        check(link_led, 1'b0, "R4 dark half before drop");
        link_ok = 1'b0;
        for (int i = 0; i < 2 * H + 1; i++) begin
            step();
            check(link_led, 1'b0, "R3 no link with carrier");
        end
        link_pol = 1'b0; #1;
        check(link_led, 1'b1, "R3 no link pin inactive pol=0");
        link_pol = 1'b1;
        // link returns with carrier still high: fresh cycle opens dark
        link_ok = 1'b1;
        step();
        check(link_led, 1'b0, "R3 fresh cycle opens dark");
        for (int i = 1; i < H; i++) begin
            step();
            check(link_led, 1'b0, "R3 fresh dark half");
        end
        step();
        check(link_led, 1'b1, "R3 fresh lit half");
        // drop link, carrier low, then return: steady lit at once
        link_ok = 1'b0; carrier = 1'b0;
        step();
        check(link_led, 1'b0, "R3 dropped");
        link_ok = 1'b1;
        step();
        check(link_led, 1'b1, "R3 R2 return steady lit");

        // R6 / R7 / R8: exhaustive speed lamp sweep
        for (int c = 0; c < 16; c++) begin
            logic exp_lit;
            speed_100 = c[0]; isolate = c[1]; speed_pol = c[2]; link_ok = c[3];
            step();
            exp_lit = c[0] && !c[1];
            if (c[1])
                check(speed_led, pin_of(1'b0, speed_pol), "R8 isolate forces dark");
            else if (!c[0])
                check(speed_led, pin_of(1'b0, speed_pol), "R7 10M dark");
            else
                check(speed_led, pin_of(exp_lit, speed_pol), "R6 100M lit");
        end

        // R9: strap takes effect without a clock edge
        speed_100 = 1'b1; isolate = 1'b0; speed_pol = 1'b1;
        step();
        check(speed_led, 1'b1, "R9 speed lit before strap flip");
        speed_pol = 1'b0; #1;
        check(speed_led, 1'b0, "R9 strap flip immediate");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule